// File: doc/BRIEF.md
# Hysteretic Digital Lock Detector

This block tells a phase-locked loop controller when its loop has settled. On every phase detector cycle it takes one strobe from the reference path and one from the feedback path and counts fast sampling-clock cycles between them. Either strobe may come first. The count from the latest cycle is shown on an output port.

Lock is raised only after a run of consecutive cycles whose error is small. After that, one cycle with a large error drops it at once. Errors between the two limits leave a held lock as it is. This gap between the acquire and release limits keeps the flag from chattering near the edge of lock.

A strobe whose partner never arrives still ends the measurement. When the counter reaches its maximum, that maximum is recorded as the error. It is therefore treated as a large error.

Top module: `phase_lock_detector`

## Requirements
- R1: While reset is asserted, `lockOut` is 0 and `errCount` is 0, and the run of good cycles is cleared. After reset, lock needs a full new run of `GOOD_RUN` good measurements.
- R2: A measurement starts on the first sampled strobe of either input. The error is the number of clock cycles from that strobe to the first strobe on the other input; strobes in the same cycle give 0. `errCount` takes the new value on the clock edge that samples the second strobe, and holds it until the next measurement ends.
- R3: If the partner strobe has not come by the time the count reaches 2^ERR_W-1, the measurement ends with `errCount` = 2^ERR_W-1. This value counts as a large error. The detector then waits for a new first strobe.
- R4: While waiting for the partner, further strobes on the leading input are ignored. They do not restart or change the count.
- R5: `lockOut` (1 = locked) rises on the edge that ends the GOOD_RUN-th consecutive measurement whose error is strictly less than ACQ_CYC.
- R6: A measurement with error ≥ ACQ_CYC clears the run of good measurements, so lock needs GOOD_RUN fresh good measurements after it.
- R7: A measurement with error strictly greater than REL_CYC clears `lockOut` on the edge that ends it.
- R8: While locked, a measurement with error from ACQ_CYC to REL_CYC inclusive leaves `lockOut` at 1.
- R9: `lockOut` changes only on edges that end a measurement. Idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| refEdge | input | 1 | One-cycle strobe marking a reference edge |
| fbEdge | input | 1 | One-cycle strobe marking a feedback edge |
| lockOut | output | 1 | Lock indication, high when locked |
| errCount | output | ERR_W | Error of the latest measurement, in clock cycles |

## Verification
The bench builds the block with ERR_W=3, ACQ_CYC=3, REL_CYC=5 and GOOD_RUN=3. With these values every error from 0 to the saturation value of 7 can be applied with either input leading. Partnerless strobes reach saturation within eight cycles.

The thresholds are small, so directed sequences can land exactly on both limits. They check that an error equal to ACQ_CYC is not good and that an error equal to REL_CYC does not release. A long pseudo-random run of measurements is then compared with an arithmetic model of the run counter and the lock flag.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  // Strobes from the pairing control to the error datapath
  typedef struct packed {
    logic startCnt;   // load count with 1 (first edge seen)
    logic stepCnt;    // advance count while waiting
    logic takeCnt;    // capture count as the error
    logic takeZero;   // capture zero (both edges in one cycle)
  } measCtl_t;

  typedef enum logic [1:0] {
    PAIR_IDLE     = 2'd0,
    PAIR_WAIT_FB  = 2'd1,
    PAIR_WAIT_REF = 2'd2
  } pairState_t;

endpackage

// File: rtl/lockdet_datapath.sv
module lockdet_datapath
  import lockdet_pkg::*;
#(
  parameter int ERR_W   = 6,
  parameter int ACQ_CYC = 15,
  parameter int REL_CYC = 25
) (
  input  logic             clk,
  input  logic             rstN,
  input  measCtl_t         ctl,
  output logic [ERR_W-1:0] errCount,
  output logic             curGood,
  output logic             curBad,
  output logic             atMax
);

  localparam logic [ERR_W-1:0] CNT_MAX = {ERR_W{1'b1}};
  localparam logic [ERR_W-1:0] ACQ_V   = ERR_W'(ACQ_CYC);
  localparam logic [ERR_W-1:0] REL_V   = ERR_W'(REL_CYC);
  localparam logic [ERR_W-1:0] ONE_V   = ERR_W'(1);

  logic [ERR_W-1:0] runCnt;
  logic [ERR_W-1:0] measVal;
  logic             takeAny;

  assign takeAny = ctl.takeCnt | ctl.takeZero;
  assign measVal = ctl.takeZero ? '0 : runCnt;
  assign atMax   = (runCnt == CNT_MAX);
  assign curGood = (measVal < ACQ_V);
  assign curBad  = (measVal > REL_V);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (ctl.startCnt) begin
      runCnt <= ONE_V;
    end else if (ctl.stepCnt && !atMax) begin
      runCnt <= runCnt + ONE_V;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errCount <= '0;
    end else if (takeAny) begin
      errCount <= measVal;
    end
  end

  // errCount moves only on a capture strobe
  assert_err_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !takeAny |=> $stable(errCount));

  // the count never wraps past its ceiling
  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    atMax && !ctl.startCnt |=> atMax || $past(takeAny) || runCnt == ONE_V);

endmodule

// File: rtl/lockdet_control.sv
module lockdet_control
  import lockdet_pkg::*;
#(
  parameter int GOOD_RUN = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     refEdge,
  input  logic     fbEdge,
  input  logic     curGood,
  input  logic     curBad,
  input  logic     atMax,
  output measCtl_t ctl,
  output logic     lockOut
);

  localparam int RUN_W = $clog2(GOOD_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_TGT = RUN_W'(GOOD_RUN);
  localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

  pairState_t pairState, pairNext;
  logic [RUN_W-1:0] goodRun, runNext;
  logic captureNow;

  // pairing of reference and feedback strobes
  always_comb begin
    pairNext = pairState;
    ctl      = '0;
    case (pairState)
      PAIR_IDLE: begin
        if (refEdge && fbEdge) begin
          ctl.takeZero = 1'b1;
        end else if (refEdge) begin
          ctl.startCnt = 1'b1;
          pairNext     = PAIR_WAIT_FB;
        end else if (fbEdge) begin
          ctl.startCnt = 1'b1;
          pairNext     = PAIR_WAIT_REF;
        end
      end
      PAIR_WAIT_FB: begin
        if (fbEdge || atMax) begin
          ctl.takeCnt = 1'b1;
          pairNext    = PAIR_IDLE;
        end else begin
          ctl.stepCnt = 1'b1;
        end
      end
      PAIR_WAIT_REF: begin
        if (refEdge || atMax) begin
          ctl.takeCnt = 1'b1;
          pairNext    = PAIR_IDLE;
        end else begin
          ctl.stepCnt = 1'b1;
        end
      end
      default: pairNext = PAIR_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) pairState <= PAIR_IDLE;
    else       pairState <= pairNext;
  end

  assign captureNow = ctl.takeCnt | ctl.takeZero;

  always_comb begin
    if (!curGood)              runNext = '0;
    else if (goodRun == RUN_TGT) runNext = goodRun;
    else                       runNext = goodRun + RUN_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      goodRun <= '0;
      lockOut <= 1'b0;
    end else if (captureNow) begin
      goodRun <= runNext;
      if (curBad)                   lockOut <= 1'b0;
      else if (runNext == RUN_TGT)  lockOut <= 1'b1;
    end
  end

  assert_lock_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockOut) |-> $past(captureNow && curGood));

  assert_lock_fall_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockOut) |-> $past(captureNow && curBad));

  assert_bad_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    captureNow && curBad |=> !lockOut);

  assert_mid_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    captureNow && !curGood && !curBad && lockOut |=> lockOut);

  assert_lead_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    pairState == PAIR_WAIT_FB && refEdge && !fbEdge && !atMax
      |=> pairState == PAIR_WAIT_FB);

endmodule

// File: rtl/phase_lock_detector.sv
module phase_lock_detector
  import lockdet_pkg::*;
#(
  parameter int ERR_W    = 6,
  parameter int ACQ_CYC  = 15,
  parameter int REL_CYC  = 25,
  parameter int GOOD_RUN = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refEdge,
  input  logic             fbEdge,
  output logic             lockOut,
  output logic [ERR_W-1:0] errCount
);

  measCtl_t measCtl;
  logic curGood, curBad, atMax;

  lockdet_control #(.GOOD_RUN(GOOD_RUN)) u_control (
    .clk     (clk),
    .rstN    (rstN),
    .refEdge (refEdge),
    .fbEdge  (fbEdge),
    .curGood (curGood),
    .curBad  (curBad),
    .atMax   (atMax),
    .ctl     (measCtl),
    .lockOut (lockOut)
  );

  lockdet_datapath #(
    .ERR_W   (ERR_W),
    .ACQ_CYC (ACQ_CYC),
    .REL_CYC (REL_CYC)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (measCtl),
    .errCount (errCount),
    .curGood  (curGood),
    .curBad   (curBad),
    .atMax    (atMax)
  );

  // simultaneous strobes from idle record a zero error
  assert_zero_pair_R2: assert property (@(posedge clk) disable iff (!rstN)
    measCtl.takeZero |=> errCount == '0);

endmodule

// File: tb/phase_lock_detector_bench.sv
module phase_lock_detector_bench;

  localparam int ERR_W    = 3;
  localparam int ACQ_CYC  = 3;
  localparam int REL_CYC  = 5;
  localparam int GOOD_RUN = 3;
  localparam int CMAX     = (1 << ERR_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refEdge = 1'b0;
  logic fbEdge = 1'b0;
  logic lockOut;
  logic [ERR_W-1:0] errCount;

  always #5 clk = ~clk;

  phase_lock_detector #(
    .ERR_W(ERR_W), .ACQ_CYC(ACQ_CYC), .REL_CYC(REL_CYC), .GOOD_RUN(GOOD_RUN)
  ) u_phase_lock_detector (
    .clk(clk), .rstN(rstN), .refEdge(refEdge), .fbEdge(fbEdge),
    .lockOut(lockOut), .errCount(errCount)
  );

  int nChecks = 0;
  int nFails = 0;
  int mRun = 0;
  bit mLock = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void modelUpdate(input int e);
    int v;
    v = (e > CMAX) ? CMAX : e;
    if (v < ACQ_CYC) mRun = (mRun < GOOD_RUN) ? mRun + 1 : mRun;
    else             mRun = 0;
    if (v > REL_CYC)          mLock = 1'b0;
    else if (mRun >= GOOD_RUN) mLock = 1'b1;
  endfunction

  task automatic setLead(input bit refLeads, input logic v);
    if (refLeads) refEdge = v; else fbEdge = v;
  endtask

  task automatic setOther(input bit refLeads, input logic v);
    if (refLeads) fbEdge = v; else refEdge = v;
  endtask

  // apply one measurement of error e, then check outputs
  task automatic pair(input int e, input bit refLeads, input string tag);
    if (e == 0) begin
      refEdge = 1'b1; fbEdge = 1'b1;
      @(negedge clk);
      refEdge = 1'b0; fbEdge = 1'b0;
    end else begin
      setLead(refLeads, 1'b1);
      @(negedge clk);
      setLead(refLeads, 1'b0);
      repeat (e - 1) @(negedge clk);
      setOther(refLeads, 1'b1);
      @(negedge clk);
      setOther(refLeads, 1'b0);
    end
    modelUpdate(e);
    check({tag, " errCount R2"}, int'(errCount), e);
    check({tag, " lockOut"}, int'(lockOut), int'(mLock));
    repeat (2) @(negedge clk);
    check({tag, " idle hold R9"}, int'(lockOut), int'(mLock));
  endtask

  task automatic lonely(input bit refLeads);
    setLead(refLeads, 1'b1);
    @(negedge clk);
    setLead(refLeads, 1'b0);
    repeat (CMAX + 1) @(negedge clk);
    modelUpdate(CMAX);
    check("R3 saturated errCount", int'(errCount), CMAX);
    check("R3 saturated lockOut", int'(lockOut), int'(mLock));
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset lockOut", int'(lockOut), 0);
    check("R1 reset errCount", int'(errCount), 0);
    rstN = 1'b1;
    mRun = 0; mLock = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: all requirements, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] lf;
    @(negedge clk);
    doReset();

    // R6: a mid error breaks the run
    pair(1, 1'b1, "R6 good1");
    pair(2, 1'b0, "R6 good2");
    pair(4, 1'b1, "R6 mid resets run");
    pair(0, 1'b0, "R6 good1b");
    pair(1, 1'b0, "R6 good2b");
    check("R6 not yet locked", int'(lockOut), 0);
    pair(2, 1'b1, "R5 third good locks");
    check("R5 locked", int'(lockOut), 1);
    // R8: errors in [ACQ, REL] keep lock
    pair(4, 1'b0, "R8 mid keeps");
    pair(5, 1'b1, "R8 at release limit keeps");
    pair(3, 1'b0, "R8 at acquire limit keeps");
    check("R8 still locked", int'(lockOut), 1);
    pair(6, 1'b0, "R7 above release clears");
    check("R7 cleared", int'(lockOut), 0);

    // R1: reset mid-lock clears lock and run
    pair(0, 1'b1, "R1 pre a");
    pair(0, 1'b1, "R1 pre b");
    pair(0, 1'b1, "R1 pre c");
    doReset();
    pair(1, 1'b1, "R1 post a");
    pair(1, 1'b0, "R1 post b");
    check("R1 run cleared by reset", int'(lockOut), 0);

    // R2: sweep every error, both leads
    for (int e = 0; e <= CMAX; e++) begin
      pair(e, 1'b1, "R2 sweep ref leads");
      pair(e, 1'b0, "R2 sweep fb leads");
    end

    // R3: lonely strobe saturates and counts as bad
    pair(0, 1'b1, "R3 pre a");
    pair(0, 1'b0, "R3 pre b");
    pair(0, 1'b1, "R3 pre c");
    lonely(1'b1);
    check("R3 saturation drops lock", int'(lockOut), 0);
    lonely(1'b0);
    pair(2, 1'b1, "R3 recovery pair");

    // R4: repeated leading strobes ignored
    refEdge = 1'b1; @(negedge clk); refEdge = 1'b0;
    @(negedge clk);
    refEdge = 1'b1; @(negedge clk); refEdge = 1'b0;
    @(negedge clk);
    fbEdge = 1'b1; @(negedge clk); fbEdge = 1'b0;
    modelUpdate(4);
    check("R4 repeat lead ignored errCount", int'(errCount), 4);
    check("R4 repeat lead lockOut", int'(lockOut), int'(mLock));
    repeat (2) @(negedge clk);

    // R5 R6 R7 R8: pseudo-random measurement stream vs model
    lf = 8'h5a;
    for (int i = 0; i < 300; i++) begin
      int e;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      e = int'(lf[2:0]);
      if (lf[7]) e = e % 3;
      pair(e, lf[3], "R5 R7 random stream");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule